// File: doc/BRIEF.md
# Mains-Synchronized Time-of-Day Counter

This block keeps calendar time by counting the cycles of the AC mains. A digital square wave from the mains is resynchronized to the system clock. It is then sampled on a separate sampling-clock enable. A level counts as valid only when two consecutive samples agree, which removes glitches. Each accepted high-to-low transition produces one cycle event.

A down-counter is reloaded with the divisor for 50 Hz or 60 Hz mains. It counts cycle events and emits a one-second tick when it runs out. The tick advances a calendar made of seconds, minutes, hours, day, month and year, with month lengths and leap years handled. Deasserting the enable stops event generation. After reset or re-enable, the filter is given two sampling periods to settle before any event is reported.

Top module: `mains_timekeeper`

## Requirements
- R1: A cycle event is produced only when the filtered input goes from high to low. A low-to-high transition never produces one.
- R2: The filter takes a new level only after two consecutive sampling-enable samples agree. A low pulse on `zc_in` that is shorter than one sampling period produces no event.
- R3: The sampling enable is high one clock in every P clocks and the synchronizer has S stages. The event appears on clock edge number S+P+1 to S+2P, counted from the falling change on `zc_in`, so the filter adds between one and two sampling periods of lag.
- R4: While `en` is low, no event is produced. After `srst` is released or `en` rises, the first two sampling enables cannot produce an event, even when the filtered level falls during them.
- R5: `cyc_evt` and `sec_tick` are each high for exactly one clock per occurrence.
- R6: With `sel_60` = 0 the divisor is DIV_LO, and with `sel_60` = 1 it is DIV_HI. `sec_tick` is high in the clock after the event that completes the divisor count. No tick occurs at any other time.
- R7: A change of `sel_60` during a count does not alter that count. The reload uses the `sel_60` value present in the clock in which the completing event is high.
- R8: The calendar changes only in the clock after `sec_tick`. Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and each wrap carries one unit into the next field.
- R9: The day wraps to 1 after the month's last day: 30 in months 4, 6, 9 and 11; 31 in the others; 28 in month 2, or 29 when the year is divisible by 4. Month 12 wraps to 1 and increments the year. Months are numbered 1 to 12 and days start at 1.
- R10: During `srst`, both pulses are low and the calendar holds the start date set by parameters. The divider is loaded from `sel_60`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables event generation |
| samp_en | input | 1 | Sampling-clock enable, one clock wide |
| zc_in | input | 1 | Raw mains square wave, asynchronous |
| sel_60 | input | 1 | 0 selects DIV_LO, 1 selects DIV_HI |
| cyc_evt | output | 1 | One-clock pulse per filtered falling edge |
| sec_tick | output | 1 | One-clock pulse per second |
| cal_sec | output | 6 | Seconds 0..59 |
| cal_min | output | 6 | Minutes 0..59 |
| cal_hour | output | 5 | Hours 0..23 |
| cal_day | output | 5 | Day of month 1..31 |
| cal_month | output | 4 | Month 1..12 |
| cal_year | output | YEAR_W | Year |

## Verification
Two things can fall in the same cycle: a divider reload and a change of the 50/60 select. The bench provokes this by flipping `sel_60` in the exact clock in which the completing `cyc_evt` is high. A monitor records the select value at each reload edge and predicts the length of the next second from that value alone. The bench then counts the events until the next tick and compares the count with the prediction. A second case flips the select in the middle of a count and checks that the running count keeps its old length. The filter lag is swept across all four sampling phases, and glitches of one to three clocks are swept at every phase.

// File: rtl/mtk_pkg.sv
package mtk_pkg;

   localparam int SEC_W   = 6;
   localparam int MIN_W   = 6;
   localparam int HOUR_W  = 5;
   localparam int DAY_W   = 5;
   localparam int MONTH_W = 4;

   function automatic logic [DAY_W-1:0] month_length(input logic [MONTH_W-1:0] month,
                                                     input logic leap);
      logic [DAY_W-1:0] len;
      case (month)
         4'd2:                      len = leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
         default:                   len = 5'd31;
      endcase
      return len;
   endfunction

endpackage

// File: rtl/mtk_zc_filter.sv
module mtk_zc_filter #(
   parameter int SYNC_STAGES    = 2,
   parameter int SETTLE_SAMPLES = 2
) (
   input  logic clk,
   input  logic srst,
   input  logic en,
   input  logic samp_en,
   input  logic zc_raw,
   output logic cyc_evt
);
   localparam int SW = $clog2(SETTLE_SAMPLES + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   smp_q;
   logic                   filt_q;
   logic [SW-1:0]          settle_q;
   logic                   armed;
   logic                   fall;
   logic                   evt_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (srst) sync_q[0] <= 1'b1;
               else      sync_q[0] <= zc_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (srst) sync_q[g] <= 1'b1;
               else      sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   assign synced = sync_q[SYNC_STAGES-1];
   assign armed  = (settle_q == SW'(SETTLE_SAMPLES));
   assign fall   = samp_en && filt_q && !smp_q && !synced;

   always_ff @(posedge clk) begin
      if (srst) begin
         smp_q    <= 1'b1;
         filt_q   <= 1'b1;
         settle_q <= '0;
         evt_q    <= 1'b0;
      end else begin
         if (samp_en) begin
            smp_q <= synced;
            if (synced == smp_q) filt_q <= synced;
         end
         if (!en)                     settle_q <= '0;
         else if (samp_en && !armed)  settle_q <= settle_q + 1'b1;
         evt_q <= en && armed && fall;
      end
   end

   assign cyc_evt = evt_q;
endmodule

// File: rtl/mtk_cycle_divider.sv
module mtk_cycle_divider #(
   parameter int DIV_LO = 50,
   parameter int DIV_HI = 60
) (
   input  logic clk,
   input  logic srst,
   input  logic sel_hi,
   input  logic cyc_evt,
   output logic sec_tick
);
   localparam int CW = $clog2(DIV_HI + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] reload;
   logic          tick_q;

   assign reload = sel_hi ? CW'(DIV_HI) : CW'(DIV_LO);

   always_ff @(posedge clk) begin
      if (srst) begin
         cnt_q  <= reload;
         tick_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (cyc_evt) begin
            if (cnt_q == CW'(1)) begin
               cnt_q  <= reload;
               tick_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign sec_tick = tick_q;
endmodule

// File: rtl/mtk_calendar.sv
module mtk_calendar
   import mtk_pkg::*;
#(
   parameter int YEAR_W      = 12,
   parameter int START_YEAR  = 2000,
   parameter int START_MONTH = 1,
   parameter int START_DAY   = 1,
   parameter int START_HOUR  = 0,
   parameter int START_MIN   = 0,
   parameter int START_SEC   = 0
) (
   input  logic               clk,
   input  logic               srst,
   input  logic               sec_tick,
   output logic [SEC_W-1:0]   cal_sec,
   output logic [MIN_W-1:0]   cal_min,
   output logic [HOUR_W-1:0]  cal_hour,
   output logic [DAY_W-1:0]   cal_day,
   output logic [MONTH_W-1:0] cal_month,
   output logic [YEAR_W-1:0]  cal_year
);
   logic [SEC_W-1:0]   sec_q;
   logic [MIN_W-1:0]   min_q;
   logic [HOUR_W-1:0]  hour_q;
   logic [DAY_W-1:0]   day_q;
   logic [MONTH_W-1:0] month_q;
   logic [YEAR_W-1:0]  year_q;
   logic               leap;
   logic [DAY_W-1:0]   last_day;

   assign leap     = (year_q[1:0] == 2'b00);
   assign last_day = month_length(month_q, leap);

   always_ff @(posedge clk) begin
      if (srst) begin
         sec_q   <= SEC_W'(START_SEC);
         min_q   <= MIN_W'(START_MIN);
         hour_q  <= HOUR_W'(START_HOUR);
         day_q   <= DAY_W'(START_DAY);
         month_q <= MONTH_W'(START_MONTH);
         year_q  <= YEAR_W'(START_YEAR);
      end else if (sec_tick) begin
         if (sec_q != SEC_W'(59)) begin
            sec_q <= sec_q + 1'b1;
         end else begin
            sec_q <= '0;
            if (min_q != MIN_W'(59)) begin
               min_q <= min_q + 1'b1;
            end else begin
               min_q <= '0;
               if (hour_q != HOUR_W'(23)) begin
                  hour_q <= hour_q + 1'b1;
               end else begin
                  hour_q <= '0;
                  if (day_q != last_day) begin
                     day_q <= day_q + 1'b1;
                  end else begin
                     day_q <= DAY_W'(1);
                     if (month_q != MONTH_W'(12)) begin
                        month_q <= month_q + 1'b1;
                     end else begin
                        month_q <= MONTH_W'(1);
                        year_q  <= year_q + 1'b1;
                     end
                  end
               end
            end
         end
      end
   end

   assign cal_sec   = sec_q;
   assign cal_min   = min_q;
   assign cal_hour  = hour_q;
   assign cal_day   = day_q;
   assign cal_month = month_q;
   assign cal_year  = year_q;
endmodule

// File: rtl/mains_timekeeper.sv
module mains_timekeeper
   import mtk_pkg::*;
#(
   parameter int DIV_LO         = 50,
   parameter int DIV_HI         = 60,
   parameter int SYNC_STAGES    = 2,
   parameter int SETTLE_SAMPLES = 2,
   parameter int YEAR_W         = 12,
   parameter int START_YEAR     = 2000,
   parameter int START_MONTH    = 1,
   parameter int START_DAY      = 1,
   parameter int START_HOUR     = 0,
   parameter int START_MIN      = 0,
   parameter int START_SEC      = 0
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              en,
   input  logic              samp_en,
   input  logic              zc_in,
   input  logic              sel_60,
   output logic              cyc_evt,
   output logic              sec_tick,
   output logic [5:0]        cal_sec,
   output logic [5:0]        cal_min,
   output logic [4:0]        cal_hour,
   output logic [4:0]        cal_day,
   output logic [3:0]        cal_month,
   output logic [YEAR_W-1:0] cal_year
);
   if (DIV_LO < 1 || DIV_HI < 1) begin : g_bad_div
      $error("mains_timekeeper: divisors must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mains_timekeeper: synchronizer needs two or more stages");
   end
   if (SETTLE_SAMPLES < 1) begin : g_bad_settle
      $error("mains_timekeeper: settle window must be at least one sample");
   end
   if (START_MONTH < 1 || START_MONTH > 12 || START_DAY < 1 || START_DAY > 31) begin : g_bad_date
      $error("mains_timekeeper: start date out of range");
   end
   if (YEAR_W < 2) begin : g_bad_year
      $error("mains_timekeeper: year field too narrow");
   end

   logic evt_w;
   logic tick_w;

   mtk_zc_filter #(
      .SYNC_STAGES   (SYNC_STAGES),
      .SETTLE_SAMPLES(SETTLE_SAMPLES)
   ) u_filter (
      .clk    (clk),
      .srst   (srst),
      .en     (en),
      .samp_en(samp_en),
      .zc_raw (zc_in),
      .cyc_evt(evt_w)
   );

   mtk_cycle_divider #(
      .DIV_LO(DIV_LO),
      .DIV_HI(DIV_HI)
   ) u_div (
      .clk     (clk),
      .srst    (srst),
      .sel_hi  (sel_60),
      .cyc_evt (evt_w),
      .sec_tick(tick_w)
   );

   mtk_calendar #(
      .YEAR_W     (YEAR_W),
      .START_YEAR (START_YEAR),
      .START_MONTH(START_MONTH),
      .START_DAY  (START_DAY),
      .START_HOUR (START_HOUR),
      .START_MIN  (START_MIN),
      .START_SEC  (START_SEC)
   ) u_cal (
      .clk      (clk),
      .srst     (srst),
      .sec_tick (tick_w),
      .cal_sec  (cal_sec),
      .cal_min  (cal_min),
      .cal_hour (cal_hour),
      .cal_day  (cal_day),
      .cal_month(cal_month),
      .cal_year (cal_year)
   );

   assign cyc_evt  = evt_w;
   assign sec_tick = tick_w;
endmodule

// File: rtl/mtk_checker.sv
module mtk_checker #(
   parameter int YEAR_W = 12
) (
   input logic              clk,
   input logic              srst,
   input logic              en,
   input logic              samp_en,
   input logic              cyc_evt,
   input logic              sec_tick,
   input logic [5:0]        cal_sec,
   input logic [5:0]        cal_min,
   input logic [4:0]        cal_hour,
   input logic [4:0]        cal_day,
   input logic [3:0]        cal_month,
   input logic [YEAR_W-1:0] cal_year
);
   logic [1:0] samples_since_on;

   always_ff @(posedge clk) begin
      if (srst || !en)                          samples_since_on <= 2'd0;
      else if (samp_en && samples_since_on != 2'd3) samples_since_on <= samples_since_on + 2'd1;
   end

   assert_evt_one_clock_R5: assert property (@(posedge clk) disable iff (srst)
      cyc_evt |=> !cyc_evt);

   assert_tick_one_clock_R5: assert property (@(posedge clk) disable iff (srst)
      sec_tick |=> !sec_tick);

   assert_tick_after_evt_R6: assert property (@(posedge clk) disable iff (srst)
      sec_tick |-> $past(cyc_evt));

   assert_settle_window_R4: assert property (@(posedge clk) disable iff (srst)
      cyc_evt |-> samples_since_on == 2'd3);

   assert_time_range_R8: assert property (@(posedge clk) disable iff (srst)
      cal_sec <= 6'd59 && cal_min <= 6'd59 && cal_hour <= 5'd23);

   assert_date_range_R9: assert property (@(posedge clk) disable iff (srst)
      cal_month >= 4'd1 && cal_month <= 4'd12 && cal_day >= 5'd1 && cal_day <= 5'd31);

   assert_cal_hold_R8: assert property (@(posedge clk) disable iff (srst)
      !$past(sec_tick) |-> $stable(cal_sec) && $stable(cal_min) && $stable(cal_day) && $stable(cal_year));

   assert_sec_step_R8: assert property (@(posedge clk) disable iff (srst)
      $past(sec_tick) |-> cal_sec == (($past(cal_sec) == 6'd59) ? 6'd0 : $past(cal_sec) + 6'd1));
endmodule

bind mains_timekeeper mtk_checker #(.YEAR_W(YEAR_W)) u_chk (
   .clk      (clk),
   .srst     (srst),
   .en       (en),
   .samp_en  (samp_en),
   .cyc_evt  (cyc_evt),
   .sec_tick (sec_tick),
   .cal_sec  (cal_sec),
   .cal_min  (cal_min),
   .cal_hour (cal_hour),
   .cal_day  (cal_day),
   .cal_month(cal_month),
   .cal_year (cal_year)
);

// File: tb/tb_mains_timekeeper.sv
module tb_mains_timekeeper;
   localparam int LO = 2;
   localparam int HI = 3;
   localparam int P  = 4;
   localparam int S  = 2;
   localparam int HALF = 16;
   localparam int YW = 12;
   localparam int NI = 5;
   localparam int ST_Y [NI] = '{2003, 2004, 2004, 2005, 2005};
   localparam int ST_M [NI] = '{12, 2, 2, 2, 4};
   localparam int ST_D [NI] = '{31, 28, 29, 28, 30};
   localparam int ST_H [NI] = '{23, 23, 23, 23, 23};
   localparam int ST_N [NI] = '{59, 59, 59, 59, 59};
   localparam int ST_S [NI] = '{55, 59, 59, 59, 59};

   logic clk = 1'b0;
   logic srst = 1'b1;
   logic en = 1'b1;
   logic sel_60 = 1'b0;
   logic man_zc = 1'b0;
   logic gen_zc = 1'b1;
   logic mains_on = 1'b0;
   logic zc_in;
   logic samp_en;
   int   ph = 0;
   int   gcnt = 0;

   logic        evt [NI];
   logic        tick [NI];
   logic [5:0]  g_sec [NI];
   logic [5:0]  g_min [NI];
   logic [4:0]  g_hour [NI];
   logic [4:0]  g_day [NI];
   logic [3:0]  g_mon [NI];
   logic [YW-1:0] g_yr [NI];

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;
   assign zc_in   = mains_on ? gen_zc : man_zc;
   assign samp_en = (ph == 0);

   always @(negedge clk) begin
      ph <= (ph + 1) % P;
      if (!mains_on) gcnt <= 0;
      else if (gcnt == HALF - 1) begin gcnt <= 0; gen_zc <= ~gen_zc; end
      else gcnt <= gcnt + 1;
   end

   mains_timekeeper #(.DIV_LO(LO), .DIV_HI(HI), .SYNC_STAGES(S), .YEAR_W(YW),
      .START_YEAR(ST_Y[0]), .START_MONTH(ST_M[0]), .START_DAY(ST_D[0]),
      .START_HOUR(ST_H[0]), .START_MIN(ST_N[0]), .START_SEC(ST_S[0])) dut (
      .clk(clk), .srst(srst), .en(en), .samp_en(samp_en), .zc_in(zc_in), .sel_60(sel_60),
      .cyc_evt(evt[0]), .sec_tick(tick[0]), .cal_sec(g_sec[0]), .cal_min(g_min[0]),
      .cal_hour(g_hour[0]), .cal_day(g_day[0]), .cal_month(g_mon[0]), .cal_year(g_yr[0]));

   for (genvar k = 1; k < NI; k++) begin : g_aux
      mains_timekeeper #(.DIV_LO(LO), .DIV_HI(HI), .SYNC_STAGES(S), .YEAR_W(YW),
         .START_YEAR(ST_Y[k]), .START_MONTH(ST_M[k]), .START_DAY(ST_D[k]),
         .START_HOUR(ST_H[k]), .START_MIN(ST_N[k]), .START_SEC(ST_S[k])) dut_aux (
         .clk(clk), .srst(srst), .en(en), .samp_en(samp_en), .zc_in(zc_in), .sel_60(sel_60),
         .cyc_evt(evt[k]), .sec_tick(tick[k]), .cal_sec(g_sec[k]), .cal_min(g_min[k]),
         .cal_hour(g_hour[k]), .cal_day(g_day[k]), .cal_month(g_mon[k]), .cal_year(g_yr[k]));
   end

   // expected calendar model
   int e_sec [NI];
   int e_min [NI];
   int e_hour [NI];
   int e_day [NI];
   int e_mon [NI];
   int e_yr [NI];

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NI; k++) begin
         e_sec[k] = ST_S[k]; e_min[k] = ST_N[k]; e_hour[k] = ST_H[k];
         e_day[k] = ST_D[k]; e_mon[k] = ST_M[k]; e_yr[k] = ST_Y[k];
      end
   endtask

   task automatic model_step();
      for (int k = 0; k < NI; k++) begin
         e_sec[k]++;
         if (e_sec[k] == 60) begin e_sec[k] = 0; e_min[k]++; end
         if (e_min[k] == 60) begin e_min[k] = 0; e_hour[k]++; end
         if (e_hour[k] == 24) begin e_hour[k] = 0; e_day[k]++; end
         if (e_day[k] > mlen(e_mon[k], e_yr[k])) begin e_day[k] = 1; e_mon[k]++; end
         if (e_mon[k] == 13) begin e_mon[k] = 1; e_yr[k]++; end
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmp_cal(input string req);
      for (int k = 0; k < NI; k++) begin
         check(g_sec[k] == 6'(e_sec[k]) && g_min[k] == 6'(e_min[k]) && g_hour[k] == 5'(e_hour[k]),
               req, int'(g_hour[k]) * 10000 + int'(g_min[k]) * 100 + int'(g_sec[k]),
               e_hour[k] * 10000 + e_min[k] * 100 + e_sec[k]);
         check(g_day[k] == 5'(e_day[k]) && g_mon[k] == 4'(e_mon[k]) && g_yr[k] == YW'(e_yr[k]),
               req, int'(g_yr[k]) * 10000 + int'(g_mon[k]) * 100 + int'(g_day[k]),
               e_yr[k] * 10000 + e_mon[k] * 100 + e_day[k]);
      end
   endtask

   // divider / calendar monitor
   logic sel_at_edge;
   int   evcount = 0;
   int   period_div = LO;
   bit   pend_tick = 0;
   bit   pend_cal = 0;
   int   n_ticks = 0;
   bit   mon_on = 0;

   always @(posedge clk) sel_at_edge <= sel_60;

   always @(negedge clk) begin
      if (srst || !mon_on) begin
         evcount = 0; pend_tick = 0; pend_cal = 0;
         period_div = sel_60 ? HI : LO;
      end else begin
         if (pend_cal) begin
            cmp_cal("R8/R9 calendar step");
            pend_cal = 0;
         end
         if (pend_tick) begin
            check(tick[0] == 1'b1, "R6 tick after completing event", int'(tick[0]), 1);
            pend_tick = 0;
            pend_cal = 1;
            n_ticks++;
            model_step();
            period_div = sel_at_edge ? HI : LO;
         end else if (tick[0]) begin
            check(1'b0, "R6/R7 tick at wrong event count", evcount, period_div);
         end
         if (evt[0]) begin
            evcount++;
            if (evcount == period_div) begin pend_tick = 1; evcount = 0; end
         end
      end
   end

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_evts(input int n, output int c);
      c = 0;
      repeat (n) begin @(negedge clk); if (evt[0]) c++; end
   endtask

   initial begin
      #1_500_000ns;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int c;
      int lag;
      int lag_min;
      int lag_max;
      int saved_sec;
      model_reset();
      clocks(6);
      // R10: reset state
      check(evt[0] == 1'b0 && tick[0] == 1'b0, "R10 pulses low in reset", int'(evt[0]) + int'(tick[0]), 0);
      cmp_cal("R10 start date");
      // R4: input already low at release, first two samples suppressed
      srst = 1'b0;
      count_evts(40, c);
      check(c == 0, "R4 settle after reset", c, 0);
      mon_on = 1;
      // R3 lag sweep over sampling phase, R1 rising edge gives nothing
      lag_min = 1000; lag_max = 0;
      for (int p = 0; p < P; p++) begin
         man_zc = 1'b1;
         count_evts(30, c);
         check(c == 0, "R1 rising edge makes no event", c, 0);
         while (ph != p) @(negedge clk);
         man_zc = 1'b0;
         lag = 0;
         for (int i = 0; i < 20; i++) begin
            @(posedge clk); lag++;
            @(negedge clk);
            if (evt[0]) break;
         end
         check(lag >= S + P + 1 && lag <= S + 2 * P, "R3 event lag", lag, S + P + 1);
         if (lag < lag_min) lag_min = lag;
         if (lag > lag_max) lag_max = lag;
         count_evts(20, c);
         check(c == 0, "R5 single event per fall", c, 0);
      end
      check(lag_min == S + P + 1, "R3 minimum lag reached", lag_min, S + P + 1);
      check(lag_max == S + 2 * P, "R3 maximum lag reached", lag_max, S + 2 * P);
      // R2 glitch sweep
      for (int w = 1; w < P; w++) begin
         for (int p = 0; p < P; p++) begin
            man_zc = 1'b1;
            clocks(24);
            while (ph != p) @(negedge clk);
            man_zc = 1'b0;
            clocks(w);
            man_zc = 1'b1;
            count_evts(24, c);
            check(c == 0, "R2 short low pulse rejected", c, 0);
         end
      end
      // R6 steady mains at both divisors
      man_zc = 1'b1;
      clocks(24);
      mains_on = 1'b1;
      clocks(HALF * 2 * 12);
      sel_60 = 1'b1;
      clocks(HALF * 2 * 15);
      // R7 mid-count change keeps the running count
      @(negedge clk iff tick[0]);
      c = 0;
      while (c < 1) begin @(negedge clk); if (evt[0]) c++; end
      sel_60 = 1'b0;
      clocks(HALF * 2 * 8);
      // R7 change in the same clock as the completing event
      for (int r = 0; r < 4; r++) begin
         @(negedge clk iff tick[0]);
         lag = sel_60 ? HI : LO;
         c = 0;
         while (c < lag) begin @(negedge clk); if (evt[0]) c++; end
         sel_60 = ~sel_60;
         clocks(HALF * 2 * 2);
      end
      clocks(HALF * 2 * 6);
      // R4 disable: no events, calendar holds
      @(negedge clk iff tick[0]);
      clocks(3);
      en = 1'b0;
      saved_sec = int'(g_sec[0]);
      count_evts(HALF * 2 * 8, c);
      check(c == 0, "R4 no events while disabled", c, 0);
      check(int'(g_sec[0]) == saved_sec, "R4 calendar holds while disabled", int'(g_sec[0]), saved_sec);
      en = 1'b1;
      clocks(HALF * 2 * 20);
      mains_on = 1'b0;
      clocks(40);
      check(n_ticks >= 20, "R6 ticks observed", n_ticks, 20);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule